// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline can move on to execute, and if it can, where each of its two ALU operands should come from. It looks at the source registers that the decode-stage instruction reads and at the destination registers of the three older instructions in execute, memory access and write-back. When the operand cannot be supplied in time, it raises a stall request. The pipeline uses that request to hold the program counter and the fetch/decode register, and to turn the execute-stage slot into a bubble with all control bits cleared.

A static two-bit mode input picks one of three forwarding policies: no bypassing at all, full bypassing from both the execute/memory and memory/write-back pipeline registers, or ALU-to-ALU bypassing only. The register file is assumed to write in the first half of a cycle and read in the second half, so a producer in write-back never causes trouble. A parameter selects a register file without that write-through property, and in that case a write-back match also stalls. The block is purely combinational from inputs to outputs. The datapath registers its forwarding selects into the execute stage alongside the instruction.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A source whose use flag is low, or whose register number is zero, never causes a stall and always gets select code 00 (register file), whatever the older instructions write.
- R2: In mode 00 (no bypassing), a used, non-zero source that matches a writing instruction in execute or in memory access raises the stall output. Both select outputs stay at 00 in this mode.
- R3: With the default write-through register file, a producer in write-back never stalls and is never forwarded from. Writers of a different register (write-after-read, write-after-write) never stall.
- R4: In modes 01 (full) and 10 (ALU-to-ALU), a non-load producer in execute of a used source gives select 01 (execute/memory register) with no stall.
- R5: In mode 01, a load in execute that writes a used source raises the stall output.
- R6: In mode 01, a producer in memory access (load or not) of a used source, with no matching execute producer, gives select 10 (memory/write-back register) with no stall.
- R7: In mode 10, any producer in memory access of a used source, with no matching execute producer, raises the stall output. Select 10 never appears in this mode.
- R8: In mode 10, a load in execute that writes a used source raises the stall output.
- R9: When both the execute and memory-access instructions write the same used source, the execute (younger) instruction decides the outcome.
- R10: Whenever the stall output is high, both select outputs are 00.
- R11: Mode code 11 behaves exactly as mode 00.
- R12: Used as the hazard control of a pipeline, three independent instructions complete write-back in 7 cycles, and each stall cycle delays completion by exactly one cycle. With a load followed directly by its consumer, this gives 9, 8 and 9 cycles in modes 00, 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used by the embedded property checks |
| rst_ni | input | 1 | Active-low reset that disables the property checks |
| mode_i | input | 2 | Forwarding policy: 00 none, 01 full, 10 ALU-to-ALU only, 11 as 00 |
| id_src_a_i | input | REG_AW | First source register of the decode-stage instruction |
| id_use_a_i | input | 1 | First source is read by the instruction |
| id_src_b_i | input | REG_AW | Second source register of the decode-stage instruction |
| id_use_b_i | input | 1 | Second source is read by the instruction |
| ex_rd_i | input | REG_AW | Destination of the execute-stage instruction |
| ex_wr_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | REG_AW | Destination of the memory-stage instruction |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | REG_AW | Destination of the write-back-stage instruction |
| wb_wr_i | input | 1 | Write-back-stage instruction writes a register |
| stall_o | output | 1 | Hold PC and fetch/decode register, insert a bubble into execute |
| fwd_a_o | output | 2 | Operand A source: 00 register file, 01 execute/memory, 10 memory/write-back |
| fwd_b_o | output | 2 | Operand B source, same coding as operand A |

## Verification
The hardest situations to reach from the ports are the ones that follow a stall: after a bubble is inserted, a load that sat in execute has moved into memory access while its consumer is still waiting in decode. This is where the modes differ most (full bypassing now forwards, ALU-to-ALU mode stalls a second time). To get there, the bench runs small instruction sequences through a behavioural pipeline model. The model moves instructions stage by stage, inserts bubbles on its own predicted stalls and drives the resulting stage contents into the block every cycle. Directed single-cycle cases then cover the priority, zero-register and reserved-mode corners.

// File: rtl/hfu_pkg.sv
`timescale 1ns/100ps
package hfu_pkg;

   typedef enum logic [1:0] {
      MODE_NONE = 2'b00,
      MODE_FULL = 2'b01,
      MODE_ALU  = 2'b10,
      MODE_RSVD = 2'b11
   } hfu_mode_e;

   typedef enum logic [1:0] {
      SEL_RF    = 2'b00,
      SEL_EXMEM = 2'b01,
      SEL_MEMWB = 2'b10
   } hfu_sel_e;

   localparam int unsigned HFU_NUM_OPND = 2;

endpackage

// File: rtl/hfu_match.sv
`timescale 1ns/100ps
module hfu_match #(
   parameter int unsigned AW = 5
) (
   input  logic [AW-1:0] src_i,
   input  logic          use_i,
   input  logic [AW-1:0] prod_rd_i,
   input  logic          prod_wr_i,
   output logic          hit_o
);

   logic src_live;

   // register zero is hard-wired and never a real dependence
   assign src_live = use_i && (src_i != '0);
   assign hit_o    = src_live && prod_wr_i && (prod_rd_i == src_i);

endmodule

// File: rtl/hfu_policy.sv
`timescale 1ns/100ps
module hfu_policy
   import hfu_pkg::*;
#(
   parameter bit RF_WRITE_THROUGH = 1'b1
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  hfu_mode_e mode_i,
   input  logic      ex_hit_i,
   input  logic      ex_load_i,
   input  logic      mem_hit_i,
   input  logic      wb_hit_i,
   output logic      stall_o,
   output hfu_sel_e  sel_o
);

   always_comb begin
      stall_o = 1'b0;
      sel_o   = SEL_RF;
      unique case (mode_i)
         MODE_FULL: begin
            if (ex_hit_i) begin
               if (ex_load_i) stall_o = 1'b1;
               else           sel_o   = SEL_EXMEM;
            end else if (mem_hit_i) begin
               sel_o = SEL_MEMWB;
            end else if (wb_hit_i) begin
               stall_o = 1'b1;
            end
         end
         MODE_ALU: begin
            if (ex_hit_i) begin
               if (ex_load_i) stall_o = 1'b1;
               else           sel_o   = SEL_EXMEM;
            end else if (mem_hit_i || wb_hit_i) begin
               stall_o = 1'b1;
            end
         end
         default: begin
            stall_o = ex_hit_i || mem_hit_i || wb_hit_i;
         end
      endcase
   end

   // ALU-to-ALU mode has no path from the memory/write-back register
   p_alu_no_memwb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_ALU) |-> (sel_o != SEL_MEMWB));

   // no bypass can be chosen without a producer in a bypassable stage
   p_sel_needs_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ex_hit_i && !mem_hit_i) |-> (sel_o == SEL_RF));

   if (RF_WRITE_THROUGH) begin : g_wt_chk
      p_wb_never_stalls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!ex_hit_i && !mem_hit_i) |-> !stall_o);
   end

endmodule

// File: rtl/hazard_fwd_unit.sv
`timescale 1ns/100ps
module hazard_fwd_unit
   import hfu_pkg::*;
#(
   parameter int unsigned REG_AW           = 5,
   parameter bit          RF_WRITE_THROUGH = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        mode_i,
   input  logic [REG_AW-1:0] id_src_a_i,
   input  logic              id_use_a_i,
   input  logic [REG_AW-1:0] id_src_b_i,
   input  logic              id_use_b_i,
   input  logic [REG_AW-1:0] ex_rd_i,
   input  logic              ex_wr_i,
   input  logic              ex_load_i,
   input  logic [REG_AW-1:0] mem_rd_i,
   input  logic              mem_wr_i,
   input  logic [REG_AW-1:0] wb_rd_i,
   input  logic              wb_wr_i,
   output logic              stall_o,
   output logic [1:0]        fwd_a_o,
   output logic [1:0]        fwd_b_o
);

   localparam int unsigned NOPND = HFU_NUM_OPND;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("hazard_fwd_unit: REG_AW out of range");
   end

   hfu_mode_e          mode;
   logic [REG_AW-1:0]  src   [NOPND];
   logic               use_s [NOPND];
   logic [NOPND-1:0]   ex_hit;
   logic [NOPND-1:0]   mem_hit;
   logic [NOPND-1:0]   wb_hit;
   logic [NOPND-1:0]   stall_req;
   hfu_sel_e           sel   [NOPND];

   assign mode     = hfu_mode_e'(mode_i);
   assign src[0]   = id_src_a_i;
   assign src[1]   = id_src_b_i;
   assign use_s[0] = id_use_a_i;
   assign use_s[1] = id_use_b_i;

   for (genvar g = 0; g < NOPND; g++) begin : g_opnd
      hfu_match #(.AW(REG_AW)) u_ex (
         .src_i     (src[g]),
         .use_i     (use_s[g]),
         .prod_rd_i (ex_rd_i),
         .prod_wr_i (ex_wr_i),
         .hit_o     (ex_hit[g])
      );
      hfu_match #(.AW(REG_AW)) u_mem (
         .src_i     (src[g]),
         .use_i     (use_s[g]),
         .prod_rd_i (mem_rd_i),
         .prod_wr_i (mem_wr_i),
         .hit_o     (mem_hit[g])
      );
      if (RF_WRITE_THROUGH) begin : g_wt
         assign wb_hit[g] = 1'b0;
      end else begin : g_nwt
         hfu_match #(.AW(REG_AW)) u_wb (
            .src_i     (src[g]),
            .use_i     (use_s[g]),
            .prod_rd_i (wb_rd_i),
            .prod_wr_i (wb_wr_i),
            .hit_o     (wb_hit[g])
         );
      end
      hfu_policy #(.RF_WRITE_THROUGH(RF_WRITE_THROUGH)) u_pol (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .mode_i    (mode),
         .ex_hit_i  (ex_hit[g]),
         .ex_load_i (ex_load_i),
         .mem_hit_i (mem_hit[g]),
         .wb_hit_i  (wb_hit[g]),
         .stall_o   (stall_req[g]),
         .sel_o     (sel[g])
      );
   end

   // a stall on either operand freezes the whole instruction
   assign stall_o = |stall_req;
   assign fwd_a_o = stall_o ? SEL_RF : sel[0];
   assign fwd_b_o = stall_o ? SEL_RF : sel[1];

   // ---------------- properties ----------------
   p_quiet_unused_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((!id_use_a_i || id_src_a_i == '0) && (!id_use_b_i || id_src_b_i == '0))
      |-> (!stall_o && fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

   p_none_mode_rf_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b00 || mode_i == 2'b11) |-> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

   p_exmem_src_ok_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_a_o == 2'b01) |-> (ex_wr_i && !ex_load_i && ex_rd_i == id_src_a_i));

   p_load_use_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i == 2'b01 || mode_i == 2'b10) && id_use_a_i && id_src_a_i != '0
       && ex_wr_i && ex_load_i && ex_rd_i == id_src_a_i) |-> stall_o);

   p_stall_clears_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o |-> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

   if (RF_WRITE_THROUGH) begin : g_wb_chk
      p_wb_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wb_wr_i && wb_rd_i != '0
          && !(ex_wr_i  && ((id_use_a_i && ex_rd_i  == id_src_a_i) || (id_use_b_i && ex_rd_i  == id_src_b_i)))
          && !(mem_wr_i && ((id_use_a_i && mem_rd_i == id_src_a_i) || (id_use_b_i && mem_rd_i == id_src_b_i))))
         |-> !stall_o);
   end

endmodule

// File: tb/hazard_fwd_unit_tb.sv
`timescale 1ns/100ps
module hazard_fwd_unit_tb;

   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_i = '0;
   logic [AW-1:0] id_src_a_i = '0, id_src_b_i = '0;
   logic          id_use_a_i = 1'b0, id_use_b_i = 1'b0;
   logic [AW-1:0] ex_rd_i = '0, mem_rd_i = '0, wb_rd_i = '0;
   logic          ex_wr_i = 1'b0, ex_load_i = 1'b0, mem_wr_i = 1'b0, wb_wr_i = 1'b0;
   logic          stall_o;
   logic [1:0]    fwd_a_o, fwd_b_o;

   int checks = 0;
   int errors = 0;

   // program storage for the pipeline model
   int p_s1 [8];
   int p_u1 [8];
   int p_s2 [8];
   int p_u2 [8];
   int p_rd [8];
   int p_wr [8];
   int p_ld [8];

   always #2.5 clk = ~clk;

   hazard_fwd_unit #(.REG_AW(AW), .RF_WRITE_THROUGH(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i),
      .id_src_a_i(id_src_a_i), .id_use_a_i(id_use_a_i),
      .id_src_b_i(id_src_b_i), .id_use_b_i(id_use_b_i),
      .ex_rd_i(ex_rd_i), .ex_wr_i(ex_wr_i), .ex_load_i(ex_load_i),
      .mem_rd_i(mem_rd_i), .mem_wr_i(mem_wr_i),
      .wb_rd_i(wb_rd_i), .wb_wr_i(wb_wr_i),
      .stall_o(stall_o), .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary_and_end();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // one-cycle directed case with explicit expectations
   task automatic dcase(input string tag, input int md,
                        input int sa, input bit ua, input int sb, input bit ub,
                        input int er, input bit ew, input bit el,
                        input int mr, input bit mw, input int wr, input bit ww,
                        input int es, input int ea, input int eb);
      @(negedge clk);
      mode_i = 2'(md);
      id_src_a_i = AW'(sa); id_use_a_i = ua;
      id_src_b_i = AW'(sb); id_use_b_i = ub;
      ex_rd_i = AW'(er); ex_wr_i = ew; ex_load_i = el;
      mem_rd_i = AW'(mr); mem_wr_i = mw;
      wb_rd_i = AW'(wr); wb_wr_i = ww;
      #1;
      chk({tag, " stall"}, int'(stall_o), es);
      chk({tag, " fwd_a"}, int'(fwd_a_o), ea);
      chk({tag, " fwd_b"}, int'(fwd_b_o), eb);
   endtask

   task automatic load_ins(input int i, input int s1, input int u1, input int s2,
                           input int u2, input int rd, input int wr, input int ld);
      p_s1[i] = s1; p_u1[i] = u1; p_s2[i] = s2; p_u2[i] = u2;
      p_rd[i] = rd; p_wr[i] = wr; p_ld[i] = ld;
   endtask

   // behavioural reference: nearest older writer decides, by distance and mode
   function automatic logic [2:0] ref_op(input int md, input int src, input int use_f,
                                         input int ex, input int mem, input int wb);
      int pr [3];
      int hit_d;
      int hit_ld;
      int m;
      pr[0] = ex; pr[1] = mem; pr[2] = wb;
      hit_d = -1; hit_ld = 0;
      for (int d = 0; d < 3; d++) begin
         if (hit_d < 0 && pr[d] >= 0) begin
            if (p_wr[pr[d]] != 0 && p_rd[pr[d]] == src) begin
               hit_d = d; hit_ld = p_ld[pr[d]];
            end
         end
      end
      if (use_f == 0 || src == 0 || hit_d < 0) return 3'b000;
      m = (md == 3) ? 0 : md;
      if (m == 0) return (hit_d < 2) ? 3'b100 : 3'b000;
      if (hit_d == 0) return (hit_ld != 0) ? 3'b100 : 3'b001;
      if (hit_d == 1) return (m == 1) ? 3'b010 : 3'b100;
      return 3'b000;
   endfunction

   task automatic drive_slots(input int md, input int id, input int ex,
                              input int mem, input int wb);
      mode_i     = 2'(md);
      id_src_a_i = (id >= 0) ? AW'(p_s1[id]) : '0;
      id_use_a_i = (id >= 0) ? (p_u1[id] != 0) : 1'b0;
      id_src_b_i = (id >= 0) ? AW'(p_s2[id]) : '0;
      id_use_b_i = (id >= 0) ? (p_u2[id] != 0) : 1'b0;
      ex_rd_i    = (ex >= 0) ? AW'(p_rd[ex]) : '0;
      ex_wr_i    = (ex >= 0) ? (p_wr[ex] != 0) : 1'b0;
      ex_load_i  = (ex >= 0) ? (p_ld[ex] != 0) : 1'b0;
      mem_rd_i   = (mem >= 0) ? AW'(p_rd[mem]) : '0;
      mem_wr_i   = (mem >= 0) ? (p_wr[mem] != 0) : 1'b0;
      wb_rd_i    = (wb >= 0) ? AW'(p_rd[wb]) : '0;
      wb_wr_i    = (wb >= 0) ? (p_wr[wb] != 0) : 1'b0;
   endtask

   // run a program through the stage model, comparing on every clock (R12)
   task automatic run_prog(input string tag, input int md, input int n, input int exp_cyc);
      int if_i, id_i, ex_i, mem_i, wb_i, nxt, done_cyc;
      logic [2:0] ra, rb;
      int st;
      if_i = 0; nxt = 1; id_i = -1; ex_i = -1; mem_i = -1; wb_i = -1; done_cyc = -1;
      for (int c = 1; c <= 40 && done_cyc < 0; c++) begin
         @(negedge clk);
         drive_slots(md, id_i, ex_i, mem_i, wb_i);
         #1;
         ra = ref_op(md, (id_i >= 0) ? p_s1[id_i] : 0, (id_i >= 0) ? p_u1[id_i] : 0, ex_i, mem_i, wb_i);
         rb = ref_op(md, (id_i >= 0) ? p_s2[id_i] : 0, (id_i >= 0) ? p_u2[id_i] : 0, ex_i, mem_i, wb_i);
         st = (ra[2] | rb[2]) ? 1 : 0;
         chk({tag, " R12 stall per cycle"}, int'(stall_o), st);
         chk({tag, " R10 fwd_a per cycle"}, int'(fwd_a_o), (st != 0) ? 0 : int'(ra[1:0]));
         chk({tag, " R10 fwd_b per cycle"}, int'(fwd_b_o), (st != 0) ? 0 : int'(rb[1:0]));
         if (wb_i == n - 1) done_cyc = c;
         wb_i = mem_i;
         mem_i = ex_i;
         if (st != 0) begin
            ex_i = -1;
         end else begin
            ex_i = id_i;
            id_i = if_i;
            if (nxt < n) begin if_i = nxt; nxt++; end
            else if_i = -1;
         end
      end
      chk({tag, " R12 completion cycle"}, done_cyc, exp_cyc);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary_and_end();
   end

   initial begin
      repeat (4) @(posedge clk);
      // quiet state right after reset: nothing pending
      @(negedge clk); #1;
      chk("R1 reset quiet stall", int'(stall_o), 0);
      chk("R1 reset quiet fwd_a", int'(fwd_a_o), 0);
      chk("R1 reset quiet fwd_b", int'(fwd_b_o), 0);
      rst_n = 1'b1;

      //        tag                        md sa ua sb ub er ew el mr mw wr ww  st a  b
      dcase("R1 zero source",            1, 0, 1, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
      dcase("R1 unused source",          1, 3, 0, 6, 0, 3, 1, 1, 6, 1, 0, 0, 0, 0, 0);
      dcase("R2 none ex producer",       0, 3, 1, 0, 0, 3, 1, 0, 0, 0, 0, 0, 1, 0, 0);
      dcase("R2 none mem producer",      0, 0, 0, 7, 1, 0, 0, 0, 7, 1, 0, 0, 1, 0, 0);
      dcase("R3 none wb producer",       0, 3, 1, 0, 0, 0, 0, 0, 0, 0, 3, 1, 0, 0, 0);
      dcase("R3 other register writer",  1, 3, 1, 5, 1, 4, 1, 1, 6, 1, 7, 1, 0, 0, 0);
      dcase("R4 full alu in ex",         1, 3, 1, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0, 1, 0);
      dcase("R4 alu-only alu in ex b",   2, 0, 0, 3, 1, 3, 1, 0, 0, 0, 0, 0, 0, 0, 1);
      dcase("R5 full load in ex",        1, 0, 0, 9, 1, 9, 1, 1, 0, 0, 0, 0, 1, 0, 0);
      dcase("R6 full producer in mem",   1, 0, 0, 9, 1, 0, 0, 0, 9, 1, 0, 0, 0, 0, 2);
      dcase("R7 alu-only mem producer",  2, 3, 1, 0, 0, 0, 0, 0, 3, 1, 0, 0, 1, 0, 0);
      dcase("R8 alu-only load in ex",    2, 3, 1, 0, 0, 3, 1, 1, 0, 0, 0, 0, 1, 0, 0);
      dcase("R9 ex beats mem",           1, 5, 1, 0, 0, 5, 1, 0, 5, 1, 0, 0, 0, 1, 0);
      dcase("R9 ex load beats mem",      1, 5, 1, 0, 0, 5, 1, 1, 5, 1, 0, 0, 1, 0, 0);
      dcase("R10 stall clears sel",      2, 3, 1, 8, 1, 3, 1, 0, 8, 1, 0, 0, 1, 0, 0);
      dcase("R11 mode 11 as none",       3, 3, 1, 0, 0, 3, 1, 0, 0, 0, 0, 0, 1, 0, 0);

      // three independent instructions
      load_ins(0, 2, 1, 3, 1, 1, 1, 0);
      load_ins(1, 4, 1, 5, 1, 6, 1, 0);
      load_ins(2, 7, 1, 8, 1, 9, 1, 0);
      run_prog("indep none", 0, 3, 7);
      run_prog("indep full", 1, 3, 7);
      run_prog("indep alu",  2, 3, 7);

      // store, load r4, then consumer of r4
      load_ins(0, 6, 1, 16, 1, 0, 0, 0);
      load_ins(1, 16, 1, 0, 0, 4, 1, 1);
      load_ins(2, 4, 1, 7, 1, 5, 1, 0);
      run_prog("load-use none", 0, 3, 9);
      run_prog("load-use full", 1, 3, 8);
      run_prog("load-use alu",  2, 3, 9);

      // chain of back-to-back ALU dependences
      load_ins(0, 2, 1, 3, 1, 1, 1, 0);
      load_ins(1, 1, 1, 4, 1, 2, 1, 0);
      load_ins(2, 2, 1, 5, 1, 1, 1, 0);
      run_prog("chain none", 0, 3, 11);
      run_prog("chain full", 1, 3, 7);
      run_prog("chain alu",  2, 3, 7);

      // ALU producer consumed two instructions later
      load_ins(0, 2, 1, 3, 1, 1, 1, 0);
      load_ins(1, 10, 1, 11, 1, 9, 1, 0);
      load_ins(2, 1, 1, 13, 1, 12, 1, 0);
      run_prog("gap2 none", 0, 3, 8);
      run_prog("gap2 full", 1, 3, 7);
      run_prog("gap2 alu",  2, 3, 8);

      summary_and_end();
   end

endmodule